// File: doc/BRIEF.md
# Stack Pointer Register Unit

This block holds the 10-bit stack pointer of a small microcontroller core. Software reaches the pointer through two byte-wide registers on the core's I/O bus: one holds the low eight bits and the other holds the remaining upper bits. The core's execution unit adjusts the pointer directly with four one-hot requests. Pushing or popping a single data byte moves the pointer by one. Saving or restoring a return address, which happens on a subroutine call, on interrupt entry and on a return, moves it by two. The pointer grows downward, so a push decrements it.

The current pointer value is always driven out to address data memory. A flag shows when the pointer sits at or below 0x060, which is the floor of the region that may hold the stack. A second flag marks a cycle in which more than one adjustment was requested. Such a cycle leaves the pointer untouched. Data memory itself, instruction decoding and the transfer of saved bytes are outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer is 0x000.
- R2: An I/O write to address 0x3D loads pointer bits 7:0 from the write data. A read of 0x3D with the read strobe high returns those bits.
- R3: An I/O write to address 0x3E loads pointer bits 9:8 from write data bits 1:0, and write data bits 7:2 are ignored. A read of 0x3E returns pointer bits 9:8 in bits 1:0 and zero in bits 7:2.
- R4: A push-byte request (`op_push_byte`) decrements the pointer by 1.
- R5: A push-address request (`op_push_addr`) decrements the pointer by 2.
- R6: A pop-byte request (`op_pop_byte`) increments the pointer by 1.
- R7: A pop-address request (`op_pop_addr`) increments the pointer by 2.
- R8: Pointer arithmetic wraps modulo 1024 in both directions.
- R9: When an I/O write to 0x3D or 0x3E occurs in the same cycle as a stack request, the write is applied and the request is dropped.
- R10: When two or more stack requests are active in one cycle, `op_conflict` is high in that cycle and the pointer does not change, unless an I/O write applies.
- R11: `sp_below_floor` is high exactly when the pointer is less than or equal to 0x060.
- R12: `io_rdata` is zero when the read strobe is low or the address is neither 0x3D nor 0x3E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| op_push_byte | input | 1 | Decrement by 1 request |
| op_pop_byte | input | 1 | Increment by 1 request |
| op_push_addr | input | 1 | Decrement by 2 request |
| op_pop_addr | input | 1 | Increment by 2 request |
| sp | output | 10 | Current stack pointer |
| sp_below_floor | output | 1 | Pointer is at or below 0x060 |
| op_conflict | output | 1 | More than one stack request in this cycle |

## Verification
The assertions check several rules on every cycle. Each single request must produce its own step on the following cycle, with wrap included. An I/O write must win over a request. A conflicting cycle must leave the pointer still, and the unused high-byte bits must read back as zero. Some properties are only shown by the bench's scenarios: the full sweep of all 1024 pointer values through both registers, the exact boundary of the floor flag at 0x060 and 0x061, the reset value, and read data staying zero for unmapped addresses.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int          PTR_W   = 10,
  parameter int          AW      = 6,
  parameter logic [AW-1:0] LO_ADDR = 6'h3D,
  parameter logic [AW-1:0] HI_ADDR = 6'h3E,
  parameter logic [PTR_W-1:0] FLOOR = 10'h060
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic             op_push_byte,
  input  logic             op_pop_byte,
  input  logic             op_push_addr,
  input  logic             op_pop_addr,
  output logic [PTR_W-1:0] sp,
  output logic             sp_below_floor,
  output logic             op_conflict
);
  localparam int HI_W = PTR_W - 8;

  logic [PTR_W-1:0] sp_q, sp_d;
  logic [3:0]       ops;
  logic             wr_lo, wr_hi, wr_any, op_single;

  assign ops       = {op_pop_addr, op_push_addr, op_pop_byte, op_push_byte};
  assign op_single = $onehot(ops);
  assign op_conflict = ($countones(ops) > 1);

  assign wr_lo  = io_wr && (io_addr == LO_ADDR);
  assign wr_hi  = io_wr && (io_addr == HI_ADDR);
  assign wr_any = wr_lo || wr_hi;

  always_comb begin
    sp_d = sp_q;
    if (wr_any) begin
      if (wr_lo) sp_d[7:0] = io_wdata;
      if (wr_hi) sp_d[PTR_W-1:8] = io_wdata[HI_W-1:0];
    end else if (op_single) begin
      unique case (1'b1)
        op_push_byte: sp_d = sp_q - PTR_W'(1);
        op_push_addr: sp_d = sp_q - PTR_W'(2);
        op_pop_byte:  sp_d = sp_q + PTR_W'(1);
        op_pop_addr:  sp_d = sp_q + PTR_W'(2);
        default:      sp_d = sp_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;

  assign sp             = sp_q;
  assign sp_below_floor = (sp_q <= FLOOR);

  always_comb begin
    io_rdata = '0;
    if (io_rd && io_addr == LO_ADDR) io_rdata = sp_q[7:0];
    else if (io_rd && io_addr == HI_ADDR) io_rdata = 8'(sp_q[PTR_W-1:8]);
  end

  p_push_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_push_byte && op_single && !wr_any) |=> (sp == PTR_W'($past(sp) - PTR_W'(1))));
  p_push_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_push_addr && op_single && !wr_any) |=> (sp == PTR_W'($past(sp) - PTR_W'(2))));
  p_pop_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pop_byte && op_single && !wr_any) |=> (sp == PTR_W'($past(sp) + PTR_W'(1))));
  p_pop_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pop_addr && op_single && !wr_any) |=> (sp == PTR_W'($past(sp) + PTR_W'(2))));
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && (ops != 4'b0)) |=> (sp[7:0] == $past(io_wdata)));
  p_conflict_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_conflict && !wr_any) |=> $stable(sp));
  p_hi_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == HI_ADDR) |-> (io_rdata[7:HI_W] == '0));
endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
  logic clk = 0, rst_n = 0;
  logic [5:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic op_push_byte = 0, op_pop_byte = 0, op_push_addr = 0, op_pop_addr = 0;
  logic [9:0] sp;
  logic sp_below_floor, op_conflict;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  stack_ptr_unit dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(logic [5:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1; #1 d = io_rdata; io_rd = 0;
  endtask

  task automatic set_sp(int v);
    io_write(6'h3D, 8'(v));
    io_write(6'h3E, 8'(v >> 8));
  endtask

  task automatic do_op(logic [3:0] o, output logic conf);
    @(negedge clk);
    {op_pop_addr, op_push_addr, op_pop_byte, op_push_byte} = o;
    #1 conf = op_conflict;
    @(negedge clk);
    {op_pop_addr, op_push_addr, op_pop_byte, op_push_byte} = 4'b0;
    #1;
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic c;
    int starts[10] = '{0, 1, 2, 'h60, 'h61, 'h62, 'h3FF, 'h3FE, 'h1FF, 'h200};
    int steps[4]   = '{-1, 1, -2, 2};
    string names[4] = '{"R4", "R6", "R5", "R7"};
    repeat (3) @(negedge clk);
    #1 chk("R1 reset", sp, 0);
    chk("R11 flag at reset", sp_below_floor, 1);
    rst_n = 1;

    for (int v = 0; v < 1024; v++) begin
      set_sp(v);
      #1 chk("R2/R3 sp", sp, v);
      chk("R11 flag", sp_below_floor, (v <= 'h60) ? 1 : 0);
      io_read(6'h3D, rd); chk("R2 lo read", rd, v & 'hFF);
      io_read(6'h3E, rd); chk("R3 hi read", rd, v >> 8);
    end

    for (int s = 0; s < 10; s++)
      for (int k = 0; k < 4; k++) begin
        set_sp(starts[s]);
        do_op(4'b1 << k, c);
        chk({names[k], " step R8"}, sp, (starts[s] + steps[k] + 1024) % 1024);
        chk("R10 no conflict single", c, 0);
      end

    set_sp('h12F);
    io_write(6'h3E, 8'hFE);
    #1 chk("R3 upper write bits ignored", sp, 'h22F);
    io_read(6'h3E, rd); chk("R3 hi pad zero", rd, 2);

    set_sp('h150);
    do_op(4'b0101, c);
    chk("R10 conflict flag", c, 1);
    chk("R10 sp held", sp, 'h150);
    do_op(4'b1111, c);
    chk("R10 conflict all", c, 1);
    chk("R10 sp held all", sp, 'h150);

    @(negedge clk);
    io_addr = 6'h3D; io_wdata = 8'h40; io_wr = 1; op_push_addr = 1;
    @(negedge clk);
    io_wr = 0; op_push_addr = 0;
    #1 chk("R9 write wins", sp, 'h140);

    io_addr = 6'h3D; io_rd = 0; #1 chk("R12 no strobe", io_rdata, 0);
    io_read(6'h3F, rd); chk("R12 unmapped", rd, 0);
    io_read(6'h3C, rd); chk("R12 unmapped low", rd, 0);
    io_write(6'h3F, 8'hAA);
    #1 chk("R12 unmapped write no effect", sp, 'h140);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule